// File: doc/BRIEF.md
# Parallel Display Bus Write Engine

This block feeds a display panel over a parallel command/data bus. Host logic pushes 8-bit, 16-bit or 32-bit values into a small write FIFO. The engine takes each entry and splits it into bus beats that are 8 or 16 bits wide, lowest byte lane first. It drives each beat with two programmable timing phases. During the first phase the write strobe is low. During the second phase the strobe is back high and the data is still held. Both phases are counted in ticks of a divided functional clock.

Chip select follows a transfer-enable input. The host raises that input to open a transfer and lowers it to close one. Chip select also stays low until any beat already in flight has finished. An idle flag tells the host when nothing is waiting and no beat is on the bus, so it can safely change the configuration or start a read elsewhere.

Top module: `disp_wr_engine`

## Requirements
- R1: After reset, cs_n and we_n are 1, idle is 1, push_ready is 1 and bus_d is 0.
- R2: A timing tick occurs every cfg_div+1 clocks, where cfg_div ranges from 0 to 7. Each beat holds we_n low for cfg_ph0+1 ticks.
- R3: Between two beats of the same FIFO entry, we_n stays high for max(cfg_ph1+1, 3) ticks. With the 6-bit field this gives 3 ticks at minimum and 64 at maximum.
- R4: With cfg_wide=0 (8-bit bus), a 32-bit push (push_size=2) produces 4 beats. They carry bits 7:0, 15:8, 23:16 and 31:24 in that order, on bus_d[7:0], with bus_d[15:8]=0.
- R5: With cfg_wide=1 (16-bit bus), a 32-bit push produces 2 beats: bits 15:0 first, then bits 31:16.
- R6: A 16-bit push (push_size=1) produces 2 byte beats when cfg_wide=0 and 1 beat when cfg_wide=1. An 8-bit push (push_size=0) produces 1 beat. On a 16-bit bus the unused upper byte of that beat is 0.
- R7: While xfer_en is 0 and no beat is in flight, cs_n is 1 and no beat starts. Pushed data waits in the FIFO and idle reads 0.
- R8: The FIFO holds DEPTH entries (default 4). push_ready is 0 when the FIFO is full, and a push made while push_ready is 0 is dropped.
- R9: idle is 1 exactly when the FIFO is empty and no beat is in flight.
- R10: we_n is low only while cs_n is low, and bus_d does not change while we_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_div | input | 3 | tick divider, factor minus one |
| cfg_wide | input | 1 | 1 = 16-bit bus beats, 0 = 8-bit |
| cfg_ph0 | input | 6 | strobe-low phase, ticks minus one |
| cfg_ph1 | input | 6 | strobe-high phase, ticks minus one (minimum 3 ticks) |
| xfer_en | input | 1 | holds chip select active for a transfer |
| push_valid | input | 1 | write request to the FIFO |
| push_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit push |
| push_data | input | 32 | pushed value, right-aligned |
| push_ready | output | 1 | FIFO can take a push |
| cs_n | output | 1 | chip select, active low |
| we_n | output | 1 | write strobe, active low |
| bus_d | output | 16 | panel data bus |
| idle | output | 1 | no write pending or in flight |

## Verification
A 32-bit word is sent on the 8-bit bus with a unit divider and again on the 16-bit bus with a divider of three. Comparing the two runs separates the lane order from the beat count, and it shows whether the strobe widths scale with the tick period. A zero and a maximum second phase confirm the minimum-3 clamp and the 64-tick top of the range. Short 16-bit and 8-bit pushes in both widths tell the beat counts apart per size. A burst pushed with the transfer disabled shows that beats are held back, that the FIFO reports full, and that the extra push is dropped.

// File: rtl/dwe_pkg.sv
package dwe_pkg;
  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2} push_sz_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} beat_st_e;

  typedef struct packed {
    logic [1:0]  size;
    logic [31:0] data;
  } fifo_ent_t;

  // number of bus beats an entry expands into
  function automatic logic [2:0] beats_for(input logic [1:0] size, input logic wide);
    case (size)
      SZ_32:   beats_for = wide ? 3'd2 : 3'd4;
      SZ_16:   beats_for = wide ? 3'd1 : 3'd2;
      default: beats_for = 3'd1;
    endcase
  endfunction

  // counter load for the strobe-high phase: at least 3 ticks
  function automatic logic [5:0] high_load(input logic [5:0] ph1);
    high_load = (ph1 < 6'd2) ? 6'd2 : ph1;
  endfunction

  // bus value for beat idx of a word
  function automatic logic [15:0] lane(input logic [31:0] d, input logic wide, input logic [1:0] idx);
    if (wide) lane = idx[0] ? d[31:16] : d[15:0];
    else begin
      case (idx)
        2'd0:    lane = {8'h00, d[7:0]};
        2'd1:    lane = {8'h00, d[15:8]};
        2'd2:    lane = {8'h00, d[23:16]};
        default: lane = {8'h00, d[31:24]};
      endcase
    end
  endfunction

  // zero the bytes a short push does not carry
  function automatic logic [31:0] trim(input logic [31:0] d, input logic [1:0] size);
    case (size)
      SZ_8:    trim = {24'h0, d[7:0]};
      SZ_16:   trim = {16'h0, d[15:0]};
      default: trim = d;
    endcase
  endfunction
endpackage

// File: rtl/dwe_tick_gen.sv
module dwe_tick_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2: with a divider above one, ticks never come back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/dwe_fifo.sv
module dwe_fifo
  import dwe_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  fifo_ent_t wdata,
  input  logic      rd,
  output fifo_ent_t head,
  output logic      empty,
  output logic      full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  fifo_ent_t       mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     count;
  logic            do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == DEPTH[AW:0]);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign head  = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_wr) begin
        mem[wp] <= wdata;
        wp <= bump(wp);
      end
      if (do_rd) rp <= bump(rp);
      count <= count + (do_wr ? 1'b1 : 1'b0) - (do_rd ? 1'b1 : 1'b0);
    end
  end

  // R8: occupancy bounded, and reads only come while data is present
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH[AW:0]);
  p_no_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !empty);
endmodule

// File: rtl/dwe_beat_seq.sv
module dwe_beat_seq
  import dwe_pkg::*;
#(
  parameter int PH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            go,
  input  logic            have,
  input  fifo_ent_t       head,
  input  logic            wide,
  input  logic [PH_W-1:0] ph0,
  input  logic [PH_W-1:0] ph1,
  output logic            pop,
  output logic            busy,
  output logic            we_n,
  output logic [15:0]     bus_d
);
  beat_st_e        st;
  logic [PH_W-1:0] cnt;
  logic [1:0]      bidx;
  logic            phase_end, last_beat, start_word;

  assign phase_end  = tick && (cnt == '0);
  assign last_beat  = ({1'b0, bidx} + 3'd1) >= beats_for(head.size, wide);
  assign start_word = (st == ST_IDLE) && tick && go && have;
  assign pop        = (st == ST_HIGH) && phase_end && last_beat;
  assign busy       = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; bidx <= '0; we_n <= 1'b1; bus_d <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_word) begin
          bidx  <= '0;
          bus_d <= lane(head.data, wide, 2'd0);
          we_n  <= 1'b0;
          cnt   <= ph0;
          st    <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            cnt  <= high_load(ph1);
            st   <= ST_HIGH;
          end else cnt <= cnt - 1'b1;
        end
        default: if (tick) begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!last_beat) begin
            bidx  <= bidx + 1'b1;
            bus_d <= lane(head.data, wide, bidx + 1'b1);
            we_n  <= 1'b0;
            cnt   <= ph0;
            st    <= ST_LOW;
          end else st <= ST_IDLE;
        end
      endcase
    end
  end

  // R10: data held steady through the strobe-low phase
  p_data_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(bus_d));
  // R3: strobe rises into a high phase of at least 3 ticks
  p_high_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (cnt >= PH_W'(2)));
endmodule

// File: rtl/disp_wr_engine.sv
module disp_wr_engine
  import dwe_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DIV_W = 3,
  parameter int PH_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_wide,
  input  logic [PH_W-1:0]  cfg_ph0,
  input  logic [PH_W-1:0]  cfg_ph1,
  input  logic             xfer_en,
  input  logic             push_valid,
  input  logic [1:0]       push_size,
  input  logic [31:0]      push_data,
  output logic             push_ready,
  output logic             cs_n,
  output logic             we_n,
  output logic [15:0]      bus_d,
  output logic             idle
);
  logic      tick, pop, busy, empty, full;
  fifo_ent_t head, wdata;

  assign wdata.size = push_size;
  assign wdata.data = trim(push_data, push_size);
  assign push_ready = !full;
  assign cs_n       = !(xfer_en || busy);
  assign idle       = empty && !busy;

  dwe_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick));

  dwe_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(push_valid), .wdata(wdata),
    .rd(pop), .head(head), .empty(empty), .full(full));

  dwe_beat_seq #(.PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(xfer_en), .have(!empty),
    .head(head), .wide(cfg_wide), .ph0(cfg_ph0), .ph1(cfg_ph1),
    .pop(pop), .busy(busy), .we_n(we_n), .bus_d(bus_d));

  // R10: strobe only inside an open chip select
  p_we_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);
  // R9: an idle engine never strobes
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> we_n);
  // R7: no beat starts without the transfer enable
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_en && we_n) |=> we_n);
endmodule

// File: tb/disp_wr_engine_bench.sv
module disp_wr_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_div = '0;
  logic cfg_wide = 1'b0;
  logic [5:0] cfg_ph0 = '0, cfg_ph1 = '0;
  logic xfer_en = 1'b0, push_valid = 1'b0;
  logic [1:0] push_size = '0;
  logic [31:0] push_data = '0;
  logic push_ready, cs_n, we_n, idle;
  logic [15:0] bus_d;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  disp_wr_engine u_disp_wr_engine (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wide(cfg_wide),
    .cfg_ph0(cfg_ph0), .cfg_ph1(cfg_ph1), .xfer_en(xfer_en),
    .push_valid(push_valid), .push_size(push_size), .push_data(push_data),
    .push_ready(push_ready), .cs_n(cs_n), .we_n(we_n), .bus_d(bus_d), .idle(idle));

  // beat monitor: data at each falling strobe, run lengths in clocks
  logic [15:0] cap [0:255];
  int lo [0:255], hi [0:255];
  int ncap = 0, run = 0;
  logic prev_we = 1'b1;
  always @(negedge clk) begin
    if (we_n !== prev_we) begin
      if (we_n == 1'b0) begin
        hi[ncap] = run; cap[ncap] = bus_d; ncap = ncap + 1;
      end else if (ncap > 0) lo[ncap-1] = run;
      run = 1;
    end else run = run + 1;
    prev_we = we_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_size = sz; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (!idle && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cs_n", cs_n, 1); chk("R1 we_n", we_n, 1);
    chk("R1 idle", idle, 1); chk("R1 ready", push_ready, 1);
    chk("R1 bus", bus_d, 0);
  endtask

  task automatic t_narrow32();
    int b;
    cfg_div = 3'd0; cfg_wide = 1'b0; cfg_ph0 = 6'd1; cfg_ph1 = 6'd0;
    xfer_en = 1'b1; b = ncap;
    push(2'd2, 32'h4433_2211);
    wait_idle();
    chk("R4 beats", ncap - b, 4);
    for (int i = 0; i < 4; i++) chk("R4 lane", cap[b+i], 16'h11 * (i + 1));
    chk("R2 low width", lo[b], 2);
    for (int i = 1; i < 4; i++) chk("R3 min high", hi[b+i], 3);
  endtask

  task automatic t_wide32();
    int b;
    cfg_div = 3'd2; cfg_wide = 1'b1; cfg_ph0 = 6'd0; cfg_ph1 = 6'd4;
    b = ncap;
    push(2'd2, 32'h8765_4321);
    wait_idle();
    chk("R5 beats", ncap - b, 2);
    chk("R5 low half", cap[b], 16'h4321);
    chk("R5 high half", cap[b+1], 16'h8765);
    chk("R2 low width div3", lo[b], 3);
    chk("R3 high width", hi[b+1], 15);
  endtask

  task automatic t_short();
    int b;
    cfg_div = 3'd0; cfg_wide = 1'b0; cfg_ph0 = 6'd0; cfg_ph1 = 6'd63;
    b = ncap;
    push(2'd1, 32'hFFFF_BEEF);
    wait_idle();
    chk("R6 16b narrow beats", ncap - b, 2);
    chk("R6 byte0", cap[b], 16'h00EF);
    chk("R6 byte1", cap[b+1], 16'h00BE);
    chk("R3 max high", hi[b+1], 64);
    cfg_ph1 = 6'd1; b = ncap;
    push(2'd0, 32'h1234_565A);
    wait_idle();
    chk("R6 8b beats", ncap - b, 1);
    chk("R6 8b data", cap[b], 16'h005A);
    cfg_wide = 1'b1; b = ncap;
    push(2'd1, 32'h7777_BEEF);
    push(2'd0, 32'hABCD_EF3C);
    wait_idle();
    chk("R6 16b wide beats", ncap - b, 2);
    chk("R6 16b wide data", cap[b], 16'hBEEF);
    chk("R6 8b wide zero top", cap[b+1], 16'h003C);
  endtask

  task automatic t_hold_full();
    int b;
    cfg_div = 3'd1; cfg_wide = 1'b1; cfg_ph0 = 6'd0; cfg_ph1 = 6'd0;
    xfer_en = 1'b0;
    wait_idle();
    b = ncap;
    for (int i = 0; i < 4; i++) push(2'd2, 32'h0101_0101 * (i + 1));
    chk("R8 full ready", push_ready, 0);
    push(2'd2, 32'hDEAD_BEEF);
    repeat (40) @(negedge clk);
    chk("R7 no beats", ncap - b, 0);
    chk("R7 cs_n high", cs_n, 1);
    chk("R9 idle pending", idle, 0);
    xfer_en = 1'b1;
    @(negedge clk);
    chk("R7 cs_n low", cs_n, 0);
    wait_idle();
    chk("R8 dropped push", ncap - b, 8);
    chk("R8 last word", cap[b+7], 16'h0404);
    chk("R9 idle after", idle, 1);
    chk("R8 ready again", push_ready, 1);
    xfer_en = 1'b0;
    @(negedge clk);
    chk("R10 cs released", cs_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_narrow32();
    t_wide32();
    t_short();
    t_hold_full();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule